// File: doc/BRIEF.md
# Software-Refilled Translation Buffer with Replacement Hint

This block translates virtual page numbers into physical page numbers with a fully associative table. Each entry carries its own page size, so one entry can map anything from a 4 KB page up to a 16 MB region. A lookup is compared against every entry in one cycle, and the registered result appears on the next cycle. That result is one of three outcomes: a translated physical address, a miss trap, or a multiple-match error.

The block never walks page tables. When a lookup finds nothing, it raises a trap, and the trap handler installs the mapping through a write port. The block keeps a true least-recently-used ordering of the entries and presents the oldest entry's index at all times. The handler can use that index as the refill slot.

Top module: `tlb_sw_refill`

## Requirements
- R1: Each cycle with `lk_valid` high gives, on the next cycle, `res_valid` high with exactly one of `res_hit`, `res_trap`, `res_multi` high. A cycle without a request gives `res_valid` low and all three flags low on the next cycle.
- R2: When exactly one valid entry matches a 4 KB entry (size code 0), `res_pa` equals the entry's 20-bit physical page number in bits [31:12], followed by the lookup address bits [11:0].
- R3: Size code s (0..6) selects a page of 4 KB times 4^s. The low 2·s bits of the page number are ignored in the tag compare and are taken from the lookup address in the result. Codes 7 and above act as code 6 (16 MB).
- R4: A lookup that matches no valid entry raises `res_trap`, with `res_hit` low and `res_pa` zero.
- R5: An entry written with `wr_valid` low never matches.
- R6: A lookup that matches two or more valid entries raises `res_multi`, with `res_hit` low and `res_pa` zero, and leaves the recency order unchanged.
- R7: A write makes the written entry the most recently used, so `lru_idx` never names it on the following cycle.
- R8: After reset every entry is invalid, every lookup traps, no result is valid, and `lru_idx` equals the highest index.
- R9: `lru_idx` always names the entry touched longest ago. Hits and writes both count as touches. If a write and a single hit happen in the same cycle, only the written entry is touched.
- R10: A lookup in the same cycle as a write is compared against the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Software entry write |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number tag |
| wr_ppn | input | 20 | Physical page number |
| wr_size | input | 3 | Page size code (4 KB · 4^code) |
| wr_valid | input | 1 | Valid bit of the written entry |
| res_valid | output | 1 | Result present (one cycle after request) |
| res_hit | output | 1 | Single match, address valid |
| res_trap | output | 1 | Miss, software refill needed |
| res_multi | output | 1 | Multiple-match error |
| res_pa | output | 32 | Translated physical address |
| lru_idx | output | 4 | Least recently used entry index |

## Verification
Two situations are hard to reach from the ports. The first is a multiple match between entries of different sizes. The second is a recency order that has been reshuffled by a long mix of hits and writes, so that it no longer follows simple write order. The random stimulus gets to both by drawing lookup and tag page numbers from a small pool, and by giving a share of writes large size codes, so overlapping regions appear often. Directed steps cover the case where a write and a lookup to the same entry happen in the same cycle, as well as size-code clamping.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int DEF_VA_W    = 32;
    localparam int DEF_OFS_W   = 12;
    localparam int DEF_SZ_W    = 3;
    localparam int DEF_SZ_MAX  = 6;
    localparam int DEF_ENTRIES = 16;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_HIT   = 2'd1,
        OUT_MISS  = 2'd2,
        OUT_MULTI = 2'd3
    } tlb_outcome_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int SZ_W    = 3,
    parameter int SZ_MAX  = 6,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [VPN_W-1:0]   wr_ppn,
    input  logic [SZ_W-1:0]    wr_size,
    input  logic               wr_valid,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic [ENTRIES-1:0] match_vec,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [VPN_W-1:0]   phys_vpn
);
    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] tag;
        logic [VPN_W-1:0] mask;
        logic [VPN_W-1:0] ppn;
    } ent_t;

    ent_t ent_d [ENTRIES];
    ent_t ent_q [ENTRIES];

    logic [VPN_W-1:0] wr_mask;
    logic [SZ_W-1:0]  sz_clamped;

    always_comb begin
        sz_clamped = (int'(wr_size) > SZ_MAX) ? SZ_W'(SZ_MAX) : wr_size;
        for (int b = 0; b < VPN_W; b++) begin
            wr_mask[b] = (b < 2 * int'(sz_clamped));
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx].valid = wr_valid;
            ent_d[wr_idx].tag   = wr_vpn;
            ent_d[wr_idx].mask  = wr_mask;
            ent_d[wr_idx].ppn   = wr_ppn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    logic [VPN_W-1:0] merged [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = ent_q[g].valid &&
                              (((ent_q[g].tag ^ lk_vpn) & ~ent_q[g].mask) == '0);
        assign merged[g]    = match_vec[g]
                              ? ((ent_q[g].ppn & ~ent_q[g].mask) | (lk_vpn & ent_q[g].mask))
                              : '0;
    end

    always_comb begin
        phys_vpn = '0;
        hit_idx  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            phys_vpn = phys_vpn | merged[i];
            hit_idx  = hit_idx | (match_vec[i] ? IDX_W'(i) : '0);
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> !ent_q[$past(wr_idx)].valid) else $error("invalid write matched"); // R5
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] lru_idx
);
    logic [IDX_W-1:0]   age_d [ENTRIES];
    logic [IDX_W-1:0]   age_q [ENTRIES];
    logic [ENTRIES-1:0] oldest_vec;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            age_d[i] = age_q[i];
            if (touch_en) begin
                if (IDX_W'(i) == touch_idx) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_idx]) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= IDX_W'(i);
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                age_q[i] <= age_d[i];
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest_vec[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lru_idx = lru_idx | (oldest_vec[i] ? IDX_W'(i) : '0);
        end
    end

    AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest_vec) == 1) else $error("recency order broken"); // R9
    AST_TOUCHED_YOUNGEST: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(touch_idx)] == '0) else $error("touch not youngest"); // R9
endmodule

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill
    import tlb_pkg::*;
#(
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int VA_W    = DEF_VA_W,
    parameter int OFS_W   = DEF_OFS_W,
    parameter int SZ_W    = DEF_SZ_W,
    parameter int SZ_MAX  = DEF_SZ_MAX,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [VPN_W-1:0] wr_ppn,
    input  logic [SZ_W-1:0]  wr_size,
    input  logic             wr_valid,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_trap,
    output logic             res_multi,
    output logic [VA_W-1:0]  res_pa,
    output logic [IDX_W-1:0] lru_idx
);
    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            trap;
        logic            multi;
        logic [VA_W-1:0] pa;
    } res_t;

    res_t res_d, res_q;

    logic [VPN_W-1:0]   lk_vpn;
    logic [ENTRIES-1:0] match_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [VPN_W-1:0]   phys_vpn;
    logic               any_match;
    logic               many_match;
    tlb_outcome_e       outcome;
    logic               touch_en;
    logic [IDX_W-1:0]   touch_idx;

    assign lk_vpn = lk_va[VA_W-1:OFS_W];

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .SZ_W    (SZ_W),
        .SZ_MAX  (SZ_MAX)
    ) i_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_vpn    (wr_vpn),
        .wr_ppn    (wr_ppn),
        .wr_size   (wr_size),
        .wr_valid  (wr_valid),
        .lk_vpn    (lk_vpn),
        .match_vec (match_vec),
        .hit_idx   (hit_idx),
        .phys_vpn  (phys_vpn)
    );

    tlb_lru #(
        .ENTRIES (ENTRIES)
    ) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .lru_idx   (lru_idx)
    );

    always_comb begin
        any_match  = |match_vec;
        many_match = |(match_vec & (match_vec - 1'b1));
        if (!lk_valid)       outcome = OUT_NONE;
        else if (many_match) outcome = OUT_MULTI;
        else if (any_match)  outcome = OUT_HIT;
        else                 outcome = OUT_MISS;

        res_d       = '0;
        res_d.valid = lk_valid;
        unique case (outcome)
            OUT_HIT: begin
                res_d.hit = 1'b1;
                res_d.pa  = {phys_vpn, lk_va[OFS_W-1:0]};
            end
            OUT_MISS:  res_d.trap  = 1'b1;
            OUT_MULTI: res_d.multi = 1'b1;
            default:   res_d.valid = 1'b0;
        endcase

        touch_en  = wr_en || (outcome == OUT_HIT);
        touch_idx = wr_en ? wr_idx : hit_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_trap  = res_q.trap;
    assign res_multi = res_q.multi;
    assign res_pa    = res_q.pa;

    AST_REQ_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid) else $error("missing result"); // R1
    AST_IDLE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_valid || res_hit || res_trap || res_multi)) else $error("spurious result"); // R1
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_trap, res_multi}) == 1) else $error("outcome not unique"); // R1
    AST_NO_PA_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_trap || res_multi) |-> res_pa == '0) else $error("address on failed lookup"); // R4
    AST_WRITE_NOT_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lru_idx != $past(wr_idx)) else $error("written entry still oldest"); // R7
endmodule

// File: tb/test_tlb_sw_refill.sv
module test_tlb_sw_refill;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [31:0] lk_va;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [19:0] wr_vpn;
    logic [19:0] wr_ppn;
    logic [2:0]  wr_size;
    logic        wr_valid;
    logic        res_valid, res_hit, res_trap, res_multi;
    logic [31:0] res_pa;
    logic [3:0]  lru_idx;

    always #2 clk = ~clk;

    tlb_sw_refill i_tlb_sw_refill (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .wr_size(wr_size), .wr_valid(wr_valid), .res_valid(res_valid),
        .res_hit(res_hit), .res_trap(res_trap), .res_multi(res_multi),
        .res_pa(res_pa), .lru_idx(lru_idx)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        m_valid [N];
    logic [19:0] m_vpn   [N];
    logic [19:0] m_ppn   [N];
    logic [19:0] m_mask  [N];
    int          order   [N];

    logic        e_valid, e_hit, e_trap, e_multi;
    logic [31:0] e_pa;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] size_mask(input logic [2:0] sz);
        int s = (sz > 3'd6) ? 6 : int'(sz);
        return 20'((32'd1 << (2 * s)) - 1);
    endfunction

    function automatic void touch(input int k);
        int pos = 0;
        for (int i = 0; i < N; i++) if (order[i] == k) pos = i;
        for (int i = pos; i > 0; i--) order[i] = order[i-1];
        order[0] = k;
    endfunction

    task automatic step(input bit we, input int idx, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic [2:0] sz, input bit v, input bit lv, input logic [31:0] va);
        int cnt = 0;
        int hi = 0;
        logic [19:0] lvpn = va[31:12];
        wr_en = we; wr_idx = 4'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_size = sz; wr_valid = v;
        lk_valid = lv; lk_va = va;
        for (int i = 0; i < N; i++) begin
            if (m_valid[i] && (((m_vpn[i] ^ lvpn) & ~m_mask[i]) == 20'd0)) begin
                cnt++;
                hi = i;
            end
        end
        e_valid = lv;
        e_hit   = lv && cnt == 1;
        e_trap  = lv && cnt == 0;
        e_multi = lv && cnt > 1;
        e_pa    = e_hit ? {((m_ppn[hi] & ~m_mask[hi]) | (lvpn & m_mask[hi])), va[11:0]} : 32'd0;
        if (we) begin
            m_valid[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_mask[idx] = size_mask(sz);
            touch(idx);
        end else if (e_hit) begin
            touch(hi);
        end
        @(negedge clk);
        chk("R1", "res_valid", 32'(res_valid), 32'(e_valid));
        chk("R4", "res_trap", 32'(res_trap), 32'(e_trap));
        chk("R6", "res_multi", 32'(res_multi), 32'(e_multi));
        chk("R2", "res_hit", 32'(res_hit), 32'(e_hit));
        chk("R3", "res_pa", res_pa, e_pa);
        chk("R9", "lru_idx", 32'(lru_idx), 32'(order[N-1]));
        if (we) chk("R7", "lru_idx vs written", 32'(lru_idx == 4'(idx)), 32'd0);
    endtask

    task automatic wr(input int idx, input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] sz, input bit v);
        step(1'b1, idx, vpn, ppn, sz, v, 1'b0, 32'd0);
    endtask

    task automatic lk(input logic [31:0] va);
        step(1'b0, 0, 20'd0, 20'd0, 3'd0, 1'b0, 1'b1, va);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_ppn[i] = '0; m_mask[i] = '0; order[i] = i;
        end
        rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; wr_en = 1'b0; wr_idx = '0;
        wr_vpn = '0; wr_ppn = '0; wr_size = '0; wr_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8", "reset res_valid", 32'(res_valid), 32'd0);
        chk("R8", "reset lru_idx", 32'(lru_idx), 32'(N - 1));

        lk(32'h1234_5678);
        chk("R8", "trap after reset", 32'(res_trap), 32'd1);

        wr(3, 20'h12345, 20'hABCDE, 3'd0, 1'b1);
        chk("R7", "lru after write", 32'(lru_idx), 32'd15);
        lk(32'h1234_5678);
        chk("R2", "4KB pa", res_pa, 32'hABCD_E678);

        wr(4, 20'h40000, 20'h55550, 3'd2, 1'b1);
        lk({20'h4000A, 12'h123});
        chk("R3", "64KB pa", res_pa, 32'h5555_A123);

        wr(6, 20'h80000, 20'h12000, 3'd7, 1'b1);
        lk({20'h80ABC, 12'h00F});
        chk("R3", "clamped size pa", res_pa, 32'h12AB_C00F);

        wr(2, 20'h77777, 20'h00001, 3'd0, 1'b0);
        lk(32'h7777_7000);
        chk("R5", "invalid entry trap", 32'(res_trap), 32'd1);

        wr(0, 20'h30000, 20'h00001, 3'd0, 1'b1);
        wr(1, 20'h30000, 20'h00002, 3'd0, 1'b1);
        lk(32'h3000_0000);
        chk("R6", "multi flag", 32'(res_multi), 32'd1);
        chk("R6", "multi pa", res_pa, 32'd0);

        wr(5, 20'h60000, 20'h11111, 3'd0, 1'b1);
        step(1'b1, 5, 20'h60000, 20'h22222, 3'd0, 1'b1, 1'b1, 32'h6000_0000);
        chk("R10", "old contents seen", res_pa, 32'h1111_1000);
        lk(32'h6000_0000);
        chk("R10", "new contents next", res_pa, 32'h2222_2000);

        for (int i = 0; i < N; i++) wr(i, 20'h90000 + 20'(i), 20'h00100 + 20'(i), 3'd0, 1'b1);
        chk("R9", "lru after fill", 32'(lru_idx), 32'd0);
        lk(32'h9000_0000);
        chk("R9", "lru after hit", 32'(lru_idx), 32'd1);

        for (int n = 0; n < 3000; n++) begin
            bit we = ($urandom % 10) < 3;
            bit lv = ($urandom % 10) < 8;
            logic [2:0] sz = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
            logic [19:0] wv = {2'($urandom % 4), 14'd0, 4'($urandom % 16)};
            logic [19:0] lvv = {2'($urandom % 4), 14'd0, 4'($urandom % 16)};
            step(we, int'($urandom % N), wv, 20'($urandom), sz, ($urandom % 8) != 0,
                 lv, {lvv, 12'($urandom)});
        end

        step(1'b0, 0, 20'd0, 20'd0, 3'd0, 1'b0, 1'b0, 32'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule